// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces memory addresses for indirect addressing. It holds several register sets, each with four registers: an index, a modify step, a buffer length and a buffer base. An access request names one set and one modify source. The block then puts that set's current index on the address output. In the same step it post-modifies the index by the modify amount. If the moved pointer leaves the window `[base, base + length)`, it is folded back by one length. The wrap needs no software action, and the window may start at any address and have any length; no alignment is needed.

There are two banks of register sets, primary and secondary, and a select input chooses between them. Accesses, register writes and register reads all work on the selected bank only. The other bank keeps its contents untouched, which suits fast context switches. A chip that has two memory buses uses two instances of this block.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset every register in both banks reads as zero and `out_valid` is low.
- R2: A register write changes the addressed field of the selected bank from the next cycle on; in the cycle of the write, the read port still shows the old value. The field code on `wr_field`/`rd_field` is 0 index, 1 modify, 2 length, 3 base.
- R3: An access in cycle t gives, in cycle t+1, `out_valid` high and `out_addr` equal to the set's index as it was in cycle t. A cycle with no access gives `out_valid` low one cycle later.
- R4: When the set's length is zero, the index after an access is index + modify, modulo 2^32, with no wrap.
- R5: When the length is non-zero and index + modify is greater than or equal to base + length, the new index is index + modify - length.
- R6: When the length is non-zero and index + modify is below base, the new index is index + modify + length.
- R7: `acc_msrc` = 0 takes the modify amount from the set's modify register; `acc_msrc` = 1 takes the signed value on `acc_imm`. Neither choice alters the stored modify register.
- R8: Writes, reads and accesses act on the bank chosen by `bank_sel` (0 primary, 1 secondary). The other bank's registers stay unchanged.
- R9: When, in one cycle, the index of a set is written and that set is accessed, the written value is the one stored; the address output still shows the old index.
- R10: An access changes only the index of the set it names.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bank_sel | input | 1 | Selects the active bank: 0 primary, 1 secondary |
| wr_en | input | 1 | Register write strobe |
| wr_field | input | 2 | Field to write (0 index, 1 modify, 2 length, 3 base) |
| wr_set | input | 4 | Register set to write |
| wr_data | input | 32 | Write value |
| rd_field | input | 2 | Field to read (same code as `wr_field`) |
| rd_set | input | 4 | Register set to read |
| rd_data | output | 32 | Read value from the active bank |
| acc_valid | input | 1 | Access request |
| acc_set | input | 4 | Register set used by the access |
| acc_msrc | input | 1 | Modify source: 0 register, 1 immediate |
| acc_imm | input | 32 | Signed immediate modify amount |
| out_valid | output | 1 | Address output is valid |
| out_addr | output | 32 | Generated address |

## Verification
A bad wrap decision, or a bad stored index, does not show up at once. It appears as a wrong `out_addr` on the next access to the same set, which is one cycle later in a back-to-back run. It can also be seen through the read port. The bench therefore walks one set with a run of back-to-back steps that cross both window edges, including steps equal to the length and landings exactly on the end address. A bank or set that is disturbed wrongly shows up when its registers are read back after activity in another bank or set.

// File: rtl/cag_pkg.sv
package cag_pkg;
    parameter int unsigned ADDR_W = 32;

    typedef enum logic [1:0] {
        FLD_INDEX  = 2'd0,
        FLD_MODIFY = 2'd1,
        FLD_LENGTH = 2'd2,
        FLD_BASE   = 2'd3
    } cag_field_e;

    typedef struct packed {
        logic [ADDR_W-1:0] index;
        logic [ADDR_W-1:0] modify;
        logic [ADDR_W-1:0] length;
        logic [ADDR_W-1:0] base;
    } cag_set_t;
endpackage

// File: rtl/cag_wrap.sv
module cag_wrap
    import cag_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic [AW-1:0] index_i,
    input  logic [AW-1:0] modify_i,
    input  logic [AW-1:0] length_i,
    input  logic [AW-1:0] base_i,
    output logic [AW-1:0] next_o
);
    localparam int unsigned EXT_W = AW + 2;

    logic signed [EXT_W-1:0] sum_w;
    logic signed [EXT_W-1:0] lo_w;
    logic signed [EXT_W-1:0] len_w;
    logic signed [EXT_W-1:0] hi_w;
    logic signed [EXT_W-1:0] res_w;

    always_comb begin
        sum_w = $signed({2'b00, index_i}) + $signed({{2{modify_i[AW-1]}}, modify_i});
        lo_w  = $signed({2'b00, base_i});
        len_w = $signed({2'b00, length_i});
        hi_w  = lo_w + len_w;
        if (length_i == '0) begin
            res_w = sum_w;
        end else if (sum_w >= hi_w) begin
            res_w = sum_w - len_w;
        end else if (sum_w < lo_w) begin
            res_w = sum_w + len_w;
        end else begin
            res_w = sum_w;
        end
        next_o = res_w[AW-1:0];
    end
endmodule

// File: rtl/cag_bank.sv
module cag_bank
    import cag_pkg::*;
#(
    parameter int unsigned NSETS = 16,
    localparam int unsigned SET_W = $clog2(NSETS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   active_i,
    input  logic                   wr_en_i,
    input  cag_field_e             wr_field_i,
    input  logic [SET_W-1:0]       wr_set_i,
    input  logic [ADDR_W-1:0]      wr_data_i,
    input  logic                   upd_en_i,
    input  logic [SET_W-1:0]       upd_set_i,
    input  logic [ADDR_W-1:0]      upd_index_i,
    output cag_set_t [NSETS-1:0]   sets_o
);
    typedef struct packed {
        cag_set_t [NSETS-1:0] sets;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (active_i && upd_en_i) begin
            st_d.sets[upd_set_i].index = upd_index_i;
        end
        // a register write overrides the post-modify of the same cycle
        if (active_i && wr_en_i) begin
            case (wr_field_i)
                FLD_INDEX:  st_d.sets[wr_set_i].index  = wr_data_i;
                FLD_MODIFY: st_d.sets[wr_set_i].modify = wr_data_i;
                FLD_LENGTH: st_d.sets[wr_set_i].length = wr_data_i;
                default:    st_d.sets[wr_set_i].base   = wr_data_i;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sets_o = st_q.sets;

    AST_INACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> $stable(st_q)); // R8

    AST_INDEX_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && wr_en_i && wr_field_i == FLD_INDEX)
        |=> st_q.sets[$past(wr_set_i)].index == $past(wr_data_i)); // R9
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
    import cag_pkg::*;
#(
    parameter int unsigned NSETS = 16,
    localparam int unsigned SET_W  = $clog2(NSETS),
    localparam int unsigned NBANKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_sel,
    input  logic              wr_en,
    input  logic [1:0]        wr_field,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [1:0]        rd_field,
    input  logic [SET_W-1:0]  rd_set,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              acc_valid,
    input  logic [SET_W-1:0]  acc_set,
    input  logic              acc_msrc,
    input  logic [ADDR_W-1:0] acc_imm,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } out_state_t;

    cag_set_t [NSETS-1:0] bank_sets [NBANKS];
    cag_set_t [NSETS-1:0] act_sets;
    cag_set_t             cur_set;
    cag_set_t             rd_entry;
    logic [ADDR_W-1:0]    mod_sel;
    logic [ADDR_W-1:0]    nxt_index;
    out_state_t           st_d, st_q;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        cag_bank #(.NSETS(NSETS)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .active_i    (bank_sel == 1'(b)),
            .wr_en_i     (wr_en),
            .wr_field_i  (cag_field_e'(wr_field)),
            .wr_set_i    (wr_set),
            .wr_data_i   (wr_data),
            .upd_en_i    (acc_valid),
            .upd_set_i   (acc_set),
            .upd_index_i (nxt_index),
            .sets_o      (bank_sets[b])
        );
    end

    assign act_sets = bank_sets[bank_sel];
    assign cur_set  = act_sets[acc_set];
    assign rd_entry = act_sets[rd_set];
    assign mod_sel  = acc_msrc ? acc_imm : cur_set.modify;

    cag_wrap #(.AW(ADDR_W)) u_wrap (
        .index_i  (cur_set.index),
        .modify_i (mod_sel),
        .length_i (cur_set.length),
        .base_i   (cur_set.base),
        .next_o   (nxt_index)
    );

    always_comb begin
        case (cag_field_e'(rd_field))
            FLD_INDEX:  rd_data = rd_entry.index;
            FLD_MODIFY: rd_data = rd_entry.modify;
            FLD_LENGTH: rd_data = rd_entry.length;
            default:    rd_data = rd_entry.base;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = acc_valid;
        if (acc_valid) begin
            st_d.addr = cur_set.index;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_addr  = st_q.addr;

    // window bounds in a wider domain for the checks below
    logic [ADDR_W+1:0] win_lo, win_hi, idx_w, nxt_w;
    logic [ADDR_W-1:0] mod_abs;
    assign win_lo  = {2'b00, cur_set.base};
    assign win_hi  = win_lo + {2'b00, cur_set.length};
    assign idx_w   = {2'b00, cur_set.index};
    assign nxt_w   = {2'b00, nxt_index};
    assign mod_abs = mod_sel[ADDR_W-1] ? (~mod_sel + 1'b1) : mod_sel;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> out_valid); // R3

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !out_valid); // R3

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cur_set.length == '0)
        |-> nxt_index == cur_set.index + mod_sel); // R4

    AST_WRAP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cur_set.length != '0 && win_hi[ADDR_W+1:ADDR_W] == 2'b00
         && idx_w >= win_lo && idx_w < win_hi && mod_abs <= cur_set.length)
        |-> (nxt_w >= win_lo && nxt_w < win_hi)); // R5
endmodule

// File: tb/circ_addr_gen_tb.sv
`timescale 1ns/1ps
module circ_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_field = '0;
    logic [3:0]  wr_set = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_field = '0;
    logic [3:0]  rd_set = '0;
    logic [31:0] rd_data;
    logic        acc_valid = 1'b0;
    logic [3:0]  acc_set = '0;
    logic        acc_msrc = 1'b0;
    logic [31:0] acc_imm = '0;
    logic        out_valid;
    logic [31:0] out_addr;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    circ_addr_gen u_dut (.*);

    // {msrc, immediate, expected address}; set 2 window is [100,107), modify reg 3
    localparam logic [64:0] VEC [10] = '{
        {1'b0, 32'd0,          32'd100},
        {1'b0, 32'd0,          32'd103},
        {1'b0, 32'd0,          32'd106}, // 109 -> 102 (R5)
        {1'b1, 32'hFFFF_FFFB,  32'd102}, // 97 -> 104 (R6)
        {1'b1, 32'd7,          32'd104}, // 111 -> 104
        {1'b1, 32'hFFFF_FFF9,  32'd104}, // 97 -> 104
        {1'b1, 32'd2,          32'd104}, // 106
        {1'b1, 32'd1,          32'd106}, // 107 -> 100 (end edge)
        {1'b1, 32'hFFFF_FFFF,  32'd100}, // 99 -> 106
        {1'b0, 32'd0,          32'd106}  // 109 -> 102
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] f, input logic [3:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_field = f; wr_set = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] f, input logic [3:0] s,
                          input logic [31:0] exp);
        rd_field = f; rd_set = s;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic access(input logic [3:0] s, input logic m, input logic [31:0] imm);
        acc_valid = 1'b1; acc_set = s; acc_msrc = m; acc_imm = imm;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
        rd_chk("R1 bank0 index", 2'd0, 4'd0, 32'd0);
        bank_sel = 1'b1;
        rd_chk("R1 bank1 length", 2'd2, 4'd15, 32'd0);
        bank_sel = 1'b0;

        // R2: old value visible during the write cycle, new value after
        wr_en = 1'b1; wr_field = 2'd3; wr_set = 4'd2; wr_data = 32'd100;
        rd_chk("R2 same cycle", 2'd3, 4'd2, 32'd0);
        @(negedge clk);
        wr_en = 1'b0;
        rd_chk("R2 next cycle", 2'd3, 4'd2, 32'd100);
        wr(2'd2, 4'd2, 32'd7);
        wr(2'd1, 4'd2, 32'd3);
        wr(2'd0, 4'd2, 32'd100);
        wr(2'd0, 4'd3, 32'd50);

        // table walk: back-to-back accesses (R3 R5 R6 R7)
        for (int i = 0; i < 10; i++) begin
            acc_valid = 1'b1; acc_set = 4'd2;
            acc_msrc = VEC[i][64]; acc_imm = VEC[i][63:32];
            @(negedge clk);
            chk("R3 valid", {31'd0, out_valid}, 32'd1);
            chk("R5/R6 addr", out_addr, VEC[i][31:0]);
        end
        acc_valid = 1'b0;
        @(negedge clk);
        chk("R3 idle", {31'd0, out_valid}, 32'd0);
        rd_chk("R5 final index", 2'd0, 4'd2, 32'd102);
        rd_chk("R7 modify kept", 2'd1, 4'd2, 32'd3);
        rd_chk("R10 other set", 2'd0, 4'd3, 32'd50);

        // R4: linear, crossing 2^32
        wr(2'd1, 4'd5, 32'd3);
        wr(2'd0, 4'd5, 32'hFFFF_FFFE);
        access(4'd5, 1'b0, 32'd0);
        chk("R4 first", out_addr, 32'hFFFF_FFFE);
        access(4'd5, 1'b0, 32'd0);
        chk("R4 second", out_addr, 32'd1);
        rd_chk("R4 index", 2'd0, 4'd5, 32'd4);

        // R9: write and access to the same set in one cycle
        wr_en = 1'b1; wr_field = 2'd0; wr_set = 4'd2; wr_data = 32'd105;
        access(4'd2, 1'b0, 32'd0);
        wr_en = 1'b0;
        chk("R9 addr", out_addr, 32'd102);
        rd_chk("R9 index", 2'd0, 4'd2, 32'd105);

        // R8: secondary bank
        bank_sel = 1'b1;
        rd_chk("R8 bank1 empty", 2'd0, 4'd2, 32'd0);
        wr(2'd0, 4'd2, 32'd500);
        rd_chk("R8 bank1 write", 2'd0, 4'd2, 32'd500);
        access(4'd2, 1'b0, 32'd0);
        chk("R8 bank1 addr", out_addr, 32'd500);
        bank_sel = 1'b0;
        rd_chk("R8 bank0 index", 2'd0, 4'd2, 32'd105);
        rd_chk("R8 bank0 length", 2'd2, 4'd2, 32'd7);
        access(4'd2, 1'b0, 32'd0);
        chk("R8 bank0 addr", out_addr, 32'd105);
        bank_sel = 1'b1;
        rd_chk("R8 bank1 held", 2'd0, 4'd2, 32'd500);
        bank_sel = 1'b0;

        finish_run();
    end
endmodule